// File: doc/BRIEF.md
# Page-Indexed, Physically-Tagged L1 Data Cache

This block is a direct-mapped first-level data cache for a core with 32-bit virtual addresses and 4 KB pages. The set index and the position inside a line come only from the low twelve address bits, and those bits are the same before and after translation. The tag and data arrays are therefore read from the raw request address at the same clock edge that the built-in translation buffer resolves the page number. In the following cycle the stored tag, which is a physical page number, is compared with the translated one.

The core issues one access at a time over a valid/ready request port and gets a one-cycle response on a read hit. A missing translation stalls the access until a translation for the faulting virtual page is written through the fill port. A read that misses in the array asks the next memory level for the whole line at its physical line address and completes when the line comes back. Writes are always forwarded to the next level. A write updates a cached copy only if the line is already present.

Top module: `vipt_dcache`

## Requirements
- R1: Out of reset, `req_ready` is high and `rsp_valid`, `tlb_miss`, `refill_req_valid` and `wt_valid` are low. Every line is invalid and the translation buffer is empty, so the first access takes a translation miss and then a line refill.
- R2: Address split. Bits 31:12 are the virtual page number. Bits 11:5 are the set index. Bits 4:2 select the 32-bit word in the 32-byte line. Word i of a refilled line is taken from bits 32i+31:32i of `refill_rsp_line`. A line size times line count larger than one page is rejected at elaboration.
- R3: If the page of an accepted access is not translated, `tlb_miss` rises in the second cycle after acceptance and `tlb_miss_vpn` shows the page number. `req_ready` stays low. The block waits until a fill with that page number arrives; fills for other pages do not release it. It then repeats the lookup in the following cycle.
- R4: The translation buffer holds 8 entries. New page numbers take entries in round-robin order starting at entry 0. A fill for a page number already held overwrites that entry's physical page and does not take a new entry.
- R5: A translated read whose line is invalid or carries another tag raises `refill_req_valid` one cycle after the lookup cycle. `refill_req_paddr` = {physical page, index, 5'b0}, held steady until `refill_rsp_valid`. In that same cycle `rsp_valid` is high with the requested word of the incoming line, and the line and its tag are stored.
- R6: A translated read that hits gives `rsp_valid` with the stored word in the cycle right after the request is accepted.
- R7: A hit requires the stored physical page to equal the translated one. Two virtual pages mapped to one physical page share lines. A different physical page at the same index misses and replaces the line.
- R8: A translated write pulses `wt_valid` together with `rsp_valid` in its lookup cycle, with `wt_paddr` = {physical page, bits 11:0} and `wt_data` = the write data. On a hit the addressed word is updated. On a miss nothing is allocated.
- R9: Only one access is in flight. `req_ready` falls after an acceptance and returns in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual byte address (word aligned) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_rdata | output | 32 | Read data, meaningful for reads |
| tlb_miss | output | 1 | Waiting for a translation |
| tlb_miss_vpn | output | 20 | Page number that needs a translation |
| tlb_fill_valid | input | 1 | Write one translation |
| tlb_fill_vpn | input | 20 | Virtual page number of the fill |
| tlb_fill_ppn | input | 20 | Physical page number of the fill |
| refill_req_valid | output | 1 | Line requested from next level |
| refill_req_paddr | output | 32 | Physical line address |
| refill_rsp_valid | input | 1 | Requested line delivered |
| refill_rsp_line | input | 256 | Line contents, word 0 in the low bits |
| wt_valid | output | 1 | Write-through strobe |
| wt_paddr | output | 32 | Physical address of the write |
| wt_data | output | 32 | Data of the write |

## Verification
The properties assume that the next level answers only while a line request is pending, and that it accepts every write-through strobe without back-pressure. The bench respects both. It drives `refill_rsp_valid` only after it has observed `refill_req_valid`, for exactly one cycle, and it has no path that could refuse a write. Translation fills are pulsed for a single cycle while the block is idle, or while it is waiting on a translation miss, so an entry never changes during a lookup. Every expected value comes from a fixed address-to-data function that the bench applies to the physical addresses it chooses.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned VA_W     = 32;
   localparam int unsigned PG_OFF_W = 12;
   localparam int unsigned PN_W     = VA_W - PG_OFF_W;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned WORD_B   = WORD_W / 8;

   typedef logic [PN_W-1:0] pn_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_TLBW = 2'd2,
      ST_FILL = 2'd3
   } cstate_e;

   typedef struct packed {
      logic              we;
      logic [VA_W-1:0]   va;
      logic [WORD_W-1:0] wdata;
   } creq_t;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb
   import vipt_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  pn_t              lk_vpn,
   output logic             lk_hit,
   output pn_t              lk_ppn,
   output logic [DEPTH-1:0] hit_vec,
   input  logic             fill_valid,
   input  pn_t              fill_vpn,
   input  pn_t              fill_ppn
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [DEPTH-1:0] vld_q;
   pn_t              vpn_q [DEPTH];
   pn_t              ppn_q [DEPTH];
   logic [DEPTH-1:0] fill_hit;
   logic [PTR_W-1:0] rr_q;
   logic             refresh;

   // parallel tag match, one comparator pair per entry
   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      assign hit_vec[g]  = vld_q[g] && (vpn_q[g] == lk_vpn);
      assign fill_hit[g] = vld_q[g] && (vpn_q[g] == fill_vpn);
   end

   assign lk_hit  = |hit_vec;
   assign refresh = |fill_hit;

   always_comb begin
      lk_ppn = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (hit_vec[i]) lk_ppn = lk_ppn | ppn_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         rr_q  <= '0;
      end else if (fill_valid && !refresh) begin
         vld_q[rr_q] <= 1'b1;
         rr_q        <= (rr_q == PTR_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_valid) begin
         if (refresh) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (fill_hit[i]) ppn_q[i] <= fill_ppn;
            end
         end else begin
            vpn_q[rr_q] <= fill_vpn;
            ppn_q[rr_q] <= fill_ppn;
         end
      end
   end
endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
   parameter int unsigned SETS  = 128,
   parameter int unsigned TAG_W = 20,
   localparam int unsigned IDX_W = $clog2(SETS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_vld,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [SETS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_mem [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         rd_vld <= 1'b0;
      end else begin
         if (wr_en) vld_q[wr_idx] <= 1'b1;
         if (rd_en) rd_vld <= vld_q[rd_idx];
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_mem[wr_idx] <= wr_tag;
      if (rd_en) rd_tag <= tag_mem[rd_idx];
   end
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store
   import vipt_pkg::*;
#(
   parameter int unsigned SETS  = 128,
   parameter int unsigned WORDS = 8,
   localparam int unsigned IDX_W  = $clog2(SETS),
   localparam int unsigned WSEL_W = $clog2(WORDS)
)(
   input  logic                        clk,
   input  logic                        rd_en,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [WORDS-1:0][WORD_W-1:0] rd_words,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic                        line_we,
   input  logic [WORDS-1:0][WORD_W-1:0] line_words,
   input  logic                        word_we,
   input  logic [WSEL_W-1:0]           word_sel,
   input  logic [WORD_W-1:0]           word_data
);
   timeunit 1ns;
   timeprecision 1ps;

   // one narrow bank per word lane, so a single-word write touches one bank
   for (genvar g = 0; g < WORDS; g++) begin : g_bank
      logic [WORD_W-1:0] bank [SETS];
      logic [WORD_W-1:0] q;

      always_ff @(posedge clk) begin
         if (line_we) begin
            bank[wr_idx] <= line_words[g];
         end else if (word_we && (word_sel == WSEL_W'(g))) begin
            bank[wr_idx] <= word_data;
         end
         if (rd_en) q <= bank[rd_idx];
      end

      assign rd_words[g] = q;
   end
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
   import vipt_pkg::*;
#(
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned NUM_LINES  = 128,
   parameter int unsigned TLB_DEPTH  = 8,
   localparam int unsigned LINE_W = LINE_BYTES * 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [31:0]       req_vaddr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              tlb_miss,
   output logic [19:0]       tlb_miss_vpn,
   input  logic              tlb_fill_valid,
   input  logic [19:0]       tlb_fill_vpn,
   input  logic [19:0]       tlb_fill_ppn,
   output logic              refill_req_valid,
   output logic [31:0]       refill_req_paddr,
   input  logic              refill_rsp_valid,
   input  logic [LINE_W-1:0] refill_rsp_line,
   output logic              wt_valid,
   output logic [31:0]       wt_paddr,
   output logic [31:0]       wt_data
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned WORDS  = LINE_BYTES / WORD_B;
   localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
   localparam int unsigned IDX_W  = $clog2(NUM_LINES);
   localparam int unsigned WSEL_W = $clog2(WORDS);
   localparam int unsigned XTRA_W = (OFF_W + IDX_W <= PG_OFF_W) ? (PG_OFF_W - OFF_W - IDX_W) : 0;
   localparam int unsigned TAG_W  = PN_W + XTRA_W;

   // elaboration-time parameter checks
   if ((1 << OFF_W) != LINE_BYTES || LINE_BYTES < 2 * WORD_B) begin : g_chk_line
      $error("LINE_BYTES must be a power of two of at least two words");
   end
   if ((1 << IDX_W) != NUM_LINES || NUM_LINES < 2) begin : g_chk_sets
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (OFF_W + IDX_W > PG_OFF_W) begin : g_chk_page
      $error("cache capacity exceeds one page; index would need translated bits");
   end
   if (TLB_DEPTH < 1) begin : g_chk_tlb
      $error("TLB_DEPTH must be at least 1");
   end

   cstate_e  st_q, st_d;
   creq_t    rq_q;
   pn_t      ppn_q;
   logic     xlat_ok_q;
   logic     accept;

   pn_t                  lk_ppn;
   logic                 lk_hit;
   logic [TLB_DEPTH-1:0] tlb_hit_vec;

   pn_t                  rq_vpn;
   logic                 fill_match;
   logic [TAG_W-1:0]     cmp_tag;
   logic                 line_vld;
   logic [TAG_W-1:0]     line_tag;
   logic                 tag_hit;
   logic                 line_we;
   logic                 word_we;

   logic [WORDS-1:0][WORD_W-1:0] arr_words;
   logic [WORDS-1:0][WORD_W-1:0] fill_words;
   logic [WORDS-1:0][WORD_W-1:0] src_words;
   logic [WSEL_W-1:0]            word_sel;
   logic [IDX_W-1:0]             rd_idx;
   logic [IDX_W-1:0]             rq_idx;

   assign accept     = req_valid && req_ready;
   assign rq_vpn     = rq_q.va[VA_W-1:PG_OFF_W];
   assign fill_match = tlb_fill_valid && (tlb_fill_vpn == rq_vpn);
   assign rd_idx     = req_vaddr[OFF_W +: IDX_W];
   assign rq_idx     = rq_q.va[OFF_W +: IDX_W];
   assign word_sel   = rq_q.va[OFF_W-1:2];
   assign fill_words = refill_rsp_line;

   // translation runs on the raw request in the accept cycle
   vipt_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_vpn     (req_vaddr[VA_W-1:PG_OFF_W]),
      .lk_hit     (lk_hit),
      .lk_ppn     (lk_ppn),
      .hit_vec    (tlb_hit_vec),
      .fill_valid (tlb_fill_valid),
      .fill_vpn   (tlb_fill_vpn),
      .fill_ppn   (tlb_fill_ppn)
   );

   // arrays start their read from untranslated offset bits at the same edge
   vipt_tag_store #(.SETS(NUM_LINES), .TAG_W(TAG_W)) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (accept),
      .rd_idx (rd_idx),
      .rd_vld (line_vld),
      .rd_tag (line_tag),
      .wr_en  (line_we),
      .wr_idx (rq_idx),
      .wr_tag (cmp_tag)
   );

   vipt_data_store #(.SETS(NUM_LINES), .WORDS(WORDS)) u_data (
      .clk        (clk),
      .rd_en      (accept),
      .rd_idx     (rd_idx),
      .rd_words   (arr_words),
      .wr_idx     (rq_idx),
      .line_we    (line_we),
      .line_words (fill_words),
      .word_we    (word_we),
      .word_sel   (word_sel),
      .word_data  (rq_q.wdata)
   );

   // stored tag: physical page, widened by offset bits the index does not cover
   if (XTRA_W == 0) begin : g_tag_page
      assign cmp_tag = ppn_q;
   end else begin : g_tag_wide
      assign cmp_tag = {ppn_q, rq_q.va[PG_OFF_W-1 -: XTRA_W]};
   end

   assign tag_hit = line_vld && (line_tag == cmp_tag);

   always_comb begin
      st_d             = st_q;
      rsp_valid        = 1'b0;
      wt_valid         = 1'b0;
      refill_req_valid = 1'b0;
      line_we          = 1'b0;
      word_we          = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (accept) st_d = ST_LOOK;
         end
         ST_LOOK: begin
            if (!xlat_ok_q) begin
               st_d = ST_TLBW;
            end else if (rq_q.we) begin
               wt_valid  = 1'b1;
               rsp_valid = 1'b1;
               word_we   = tag_hit;
               st_d      = ST_IDLE;
            end else if (tag_hit) begin
               rsp_valid = 1'b1;
               st_d      = ST_IDLE;
            end else begin
               st_d = ST_FILL;
            end
         end
         ST_TLBW: begin
            if (fill_match) st_d = ST_LOOK;
         end
         ST_FILL: begin
            refill_req_valid = 1'b1;
            if (refill_rsp_valid) begin
               line_we   = 1'b1;
               rsp_valid = 1'b1;
               st_d      = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         rq_q      <= '0;
         ppn_q     <= '0;
         xlat_ok_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            rq_q      <= '{we: req_we, va: req_vaddr, wdata: req_wdata};
            xlat_ok_q <= lk_hit;
            ppn_q     <= lk_ppn;
         end else if ((st_q == ST_TLBW) && fill_match) begin
            xlat_ok_q <= 1'b1;
            ppn_q     <= tlb_fill_ppn;
         end
      end
   end

   assign src_words        = (st_q == ST_FILL) ? fill_words : arr_words;
   assign rsp_rdata        = src_words[word_sel];
   assign req_ready        = (st_q == ST_IDLE);
   assign tlb_miss         = (st_q == ST_TLBW);
   assign tlb_miss_vpn     = rq_vpn;
   assign refill_req_paddr = {ppn_q, rq_q.va[PG_OFF_W-1:OFF_W], {OFF_W{1'b0}}};
   assign wt_paddr         = {ppn_q, rq_q.va[PG_OFF_W-1:0]};
   assign wt_data          = rq_q.wdata;
endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk
   import vipt_pkg::*;
#(
   parameter int unsigned TLB_DEPTH  = 8,
   parameter int unsigned LINE_BYTES = 32
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic                 rsp_valid,
   input logic                 tlb_miss,
   input logic [19:0]          tlb_miss_vpn,
   input logic                 tlb_fill_valid,
   input logic [19:0]          tlb_fill_vpn,
   input logic                 refill_req_valid,
   input logic [31:0]          refill_req_paddr,
   input logic                 refill_rsp_valid,
   input logic                 wt_valid,
   input logic [TLB_DEPTH-1:0] tlb_hit_vec
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned OFF_W = $clog2(LINE_BYTES);

   // R9: an accepted request closes the port on the next cycle
   a_r9_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9: after a response the port reopens
   a_r9_reopen_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready);

   // R3: waiting persists until the matching page is filled
   a_r3_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_miss && !(tlb_fill_valid && tlb_fill_vpn == tlb_miss_vpn))
      |=> (tlb_miss && $stable(tlb_miss_vpn)));

   // R3: a matching fill ends the wait
   a_r3_miss_release: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_miss && tlb_fill_valid && tlb_fill_vpn == tlb_miss_vpn) |=> !tlb_miss);

   // R4: no page number ever sits in two entries
   a_r4_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tlb_hit_vec));

   // R5: refill request stays up with a steady address until answered
   a_r5_refill_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_req_valid && !refill_rsp_valid)
      |=> (refill_req_valid && $stable(refill_req_paddr)));

   // R5: line address carries no byte offset
   a_r5_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      refill_req_valid |-> (refill_req_paddr[OFF_W-1:0] == '0));

   // R8: every forwarded write is also the completion of the access
   a_r8_wt_completes: assert property (@(posedge clk) disable iff (!rst_n)
      wt_valid |-> (rsp_valid && !refill_req_valid));
endmodule

bind vipt_dcache vipt_dcache_chk #(
   .TLB_DEPTH  (TLB_DEPTH),
   .LINE_BYTES (LINE_BYTES)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .req_valid        (req_valid),
   .req_ready        (req_ready),
   .rsp_valid        (rsp_valid),
   .tlb_miss         (tlb_miss),
   .tlb_miss_vpn     (tlb_miss_vpn),
   .tlb_fill_valid   (tlb_fill_valid),
   .tlb_fill_vpn     (tlb_fill_vpn),
   .refill_req_valid (refill_req_valid),
   .refill_req_paddr (refill_req_paddr),
   .refill_rsp_valid (refill_rsp_valid),
   .wt_valid         (wt_valid),
   .tlb_hit_vec      (tlb_hit_vec)
);

// File: tb/vipt_dcache_tb.sv
module vipt_dcache_tb;
   timeunit 1ns;
   timeprecision 1ps;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic         req_we = 1'b0;
   logic [31:0]  req_vaddr = '0;
   logic [31:0]  req_wdata = '0;
   logic         rsp_valid;
   logic [31:0]  rsp_rdata;
   logic         tlb_miss;
   logic [19:0]  tlb_miss_vpn;
   logic         tlb_fill_valid = 1'b0;
   logic [19:0]  tlb_fill_vpn = '0;
   logic [19:0]  tlb_fill_ppn = '0;
   logic         refill_req_valid;
   logic [31:0]  refill_req_paddr;
   logic         refill_rsp_valid = 1'b0;
   logic [255:0] refill_rsp_line = '0;
   logic         wt_valid;
   logic [31:0]  wt_paddr;
   logic [31:0]  wt_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   vipt_dcache u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_vaddr(req_vaddr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .tlb_miss(tlb_miss), .tlb_miss_vpn(tlb_miss_vpn),
      .tlb_fill_valid(tlb_fill_valid), .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_ppn(tlb_fill_ppn),
      .refill_req_valid(refill_req_valid), .refill_req_paddr(refill_req_paddr),
      .refill_rsp_valid(refill_rsp_valid), .refill_rsp_line(refill_rsp_line),
      .wt_valid(wt_valid), .wt_paddr(wt_paddr), .wt_data(wt_data)
   );

   function automatic logic [31:0] word_val(input logic [31:0] pa);
      return pa ^ 32'h6C3E_9000;
   endfunction

   function automatic logic [255:0] mk_line(input logic [31:0] base);
      logic [255:0] l;
      for (int i = 0; i < 8; i++) l[i*32 +: 32] = word_val(base + 32'(i * 4));
      return l;
   endfunction

   task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // drive one request; returns at the falling edge after acceptance
   task automatic issue(input logic we, input logic [31:0] va, input logic [31:0] wd);
      @(negedge clk);
      chk("R9", "ready before issue", req_ready, 1);
      req_valid = 1'b1; req_we = we; req_vaddr = va; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0;
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn);
      @(negedge clk);
      tlb_fill_valid = 1'b1; tlb_fill_vpn = vpn; tlb_fill_ppn = ppn;
      @(negedge clk);
      tlb_fill_valid = 1'b0;
   endtask

   task automatic expect_hit(input string rq, input logic [31:0] exp);
      chk(rq, "hit rsp_valid", rsp_valid, 1);
      chk(rq, "hit rdata", rsp_rdata, exp);
      chk("R9", "ready low while responding", req_ready, 0);
   endtask

   task automatic expect_write(input string rq, input logic [31:0] pa, input logic [31:0] d);
      chk(rq, "wt_valid", wt_valid, 1);
      chk(rq, "wt_paddr", wt_paddr, pa);
      chk(rq, "wt_data", wt_data, d);
      chk(rq, "write rsp_valid", rsp_valid, 1);
   endtask

   // called in the lookup cycle of a read miss
   task automatic serve_refill(input string rq, input logic [31:0] line_pa, input int lat, input logic [31:0] exp);
      chk(rq, "no rsp in miss lookup", rsp_valid, 0);
      @(negedge clk);
      chk(rq, "refill_req_valid", refill_req_valid, 1);
      chk(rq, "refill_req_paddr", refill_req_paddr, line_pa);
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         chk(rq, "refill request held", {refill_req_valid, req_ready}, 2'b10);
      end
      refill_rsp_valid = 1'b1;
      refill_rsp_line  = mk_line(line_pa);
      #1;
      chk(rq, "refill rsp_valid", rsp_valid, 1);
      chk(rq, "refill rdata", rsp_rdata, exp);
      @(negedge clk);
      refill_rsp_valid = 1'b0;
      chk("R9", "ready after refill", req_ready, 1);
   endtask

   // called in the lookup cycle of an untranslated access
   task automatic tlb_resolve(input string rq, input logic [19:0] vpn, input logic [19:0] ppn);
      chk(rq, "no rsp without translation", rsp_valid, 0);
      @(negedge clk);
      chk(rq, "tlb_miss raised", tlb_miss, 1);
      chk(rq, "tlb_miss_vpn", tlb_miss_vpn, vpn);
      chk(rq, "ready low during miss", req_ready, 0);
      tlb_fill_valid = 1'b1; tlb_fill_vpn = vpn; tlb_fill_ppn = ppn;
      @(negedge clk);
      tlb_fill_valid = 1'b0;
      chk(rq, "tlb_miss released", tlb_miss, 0);
   endtask

   task automatic t_reset();
      chk("R1", "ready after reset", req_ready, 1);
      chk("R1", "idle outputs", {rsp_valid, tlb_miss, refill_req_valid, wt_valid}, 4'b0000);
   endtask

   task automatic t_tlb_miss();
      issue(1'b0, 32'h0040_1234, '0);
      chk("R3", "no rsp on lookup", {rsp_valid, wt_valid}, 2'b00);
      @(negedge clk);
      chk("R3", "tlb_miss raised", tlb_miss, 1);
      chk("R3", "tlb_miss_vpn", tlb_miss_vpn, 20'h00401);
      tlb_fill_valid = 1'b1; tlb_fill_vpn = 20'h00777; tlb_fill_ppn = 20'h12345;
      @(negedge clk);
      tlb_fill_valid = 1'b0;
      chk("R3", "other page fill ignored", {tlb_miss, req_ready}, 2'b10);
      tlb_fill_valid = 1'b1; tlb_fill_vpn = 20'h00401; tlb_fill_ppn = 20'h80A10;
      @(negedge clk);
      tlb_fill_valid = 1'b0;
      chk("R3", "retry after fill", tlb_miss, 0);
      // R1: line invalid after reset, refill expected
      serve_refill("R1", 32'h80A1_0220, 2, word_val(32'h80A1_0234));
   endtask

   task automatic t_read_hit();
      issue(1'b0, 32'h0040_1238, '0);
      expect_hit("R6", word_val(32'h80A1_0238));
   endtask

   task automatic t_line_fill();
      fill(20'h00402, 20'h33333);
      issue(1'b0, 32'h0040_2FFC, '0);
      serve_refill("R5", 32'h3333_3FE0, 0, word_val(32'h3333_3FFC));
      issue(1'b0, 32'h0040_2FE0, '0);
      expect_hit("R2", word_val(32'h3333_3FE0));
   endtask

   task automatic t_phys_tag();
      fill(20'h00500, 20'h80A10);
      issue(1'b0, 32'h0050_0230, '0);
      expect_hit("R7", word_val(32'h80A1_0230));
      fill(20'h00600, 20'h44444);
      issue(1'b0, 32'h0060_0234, '0);
      serve_refill("R7", 32'h4444_4220, 1, word_val(32'h4444_4234));
      issue(1'b0, 32'h0040_1234, '0);
      serve_refill("R7", 32'h80A1_0220, 0, word_val(32'h80A1_0234));
   endtask

   task automatic t_write();
      issue(1'b1, 32'h0040_1238, 32'hDEAD_BEEF);
      expect_write("R8", 32'h80A1_0238, 32'hDEAD_BEEF);
      issue(1'b0, 32'h0050_0238, '0);
      expect_hit("R8", 32'hDEAD_BEEF);
      issue(1'b1, 32'h0040_2000, 32'h0123_4567);
      expect_write("R8", 32'h3333_3000, 32'h0123_4567);
      issue(1'b0, 32'h0040_2000, '0);
      serve_refill("R8", 32'h3333_3000, 1, word_val(32'h3333_3000));
   endtask

   task automatic t_tlb_replace();
      fill(20'h00402, 20'h55555);
      issue(1'b0, 32'h0040_2FFC, '0);
      serve_refill("R4", 32'h5555_5FE0, 0, word_val(32'h5555_5FFC));
      for (int i = 0; i < 5; i++) fill(20'h00A00 + 20'(i), 20'h0B000 + 20'(i));
      issue(1'b0, 32'h0050_0238, '0);
      expect_hit("R4", 32'hDEAD_BEEF);
      issue(1'b0, 32'h0040_1238, '0);
      tlb_resolve("R4", 20'h00401, 20'h80A10);
      expect_hit("R4", 32'hDEAD_BEEF);
      issue(1'b0, 32'h0040_2000, '0);
      tlb_resolve("R4", 20'h00402, 20'h33333);
      expect_hit("R4", word_val(32'h3333_3000));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tlb_miss();
      t_read_hit();
      t_line_fill();
      t_phys_tag();
      t_write();
      t_tlb_replace();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule